// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Indirect Addressing

This control unit handles the cycle order of a 36-bit word machine. For every instruction it runs a fetch cycle (I). The opcode then selects what follows. Single-cycle instructions finish in the I cycle. Other instructions go on to an execute cycle (E) or a long cycle (L), picked by the octal range of the primary code. An indexable instruction that has both indirect flag bits set gets one extra indirect cycle (IND) first. The IND cycle replaces the address register with the address field of the word it reads.

Every storage access goes through one read port with a request/valid handshake. The sequencer waits in its current cycle until the read data is valid. The datapath sees the current cycle on `cyc_o` and a registered end-of-operation flag on `eop_o`. The block also exposes the program counter, storage register, program register, address register and shift counter that it loads.

Two parameter bitmaps, each indexed by the 9-bit primary code, mark which codes are single-cycle and which are indexable. Arithmetic, shifting, index-register arithmetic and I/O lie outside this block.

Top module: `icseq_top`

## Requirements
- R1: Cycle codes on `cyc_o` are I=0, IND=1, E=2, L=3. A synchronous active-low reset puts the block in an I cycle with `eop_o`=1, the program counter at RESET_PC (default 0), and the address register, shift counter, storage and program registers at zero.
- R2: An I cycle requests a read at the program counter. On valid data, the word goes into the storage register and word bits [35:24] go into the program register. The program counter then steps by one.
- R3: On fetch, the address field (word bits [14:0]) goes into the address register. The exception is a word whose bits [35:30] equal octal 76: for that word, bits [7:0] go into the shift counter and the address register keeps its value.
- R4: The primary code is word bits [35:27]. A code of octal 177 or below, or octal 700 or above, is followed by an L cycle. Any other code is followed by an E cycle.
- R5: An instruction marked single-cycle runs only its I cycle. The next cycle is again I, whatever its range or flag bits.
- R6: An instruction marked indexable, with both word bits 23 and 22 set, gets an IND cycle after I. The IND cycle reads at the address register and loads the address register from bits [14:0] of the word read. It leaves the storage and program registers unchanged. The E or L cycle chosen by R4 follows, and the flag bits of the indirect word are ignored.
- R7: No IND cycle is inserted if the instruction is not indexable or has only one of bits 23/22 set.
- R8: While a read request is pending without valid data, the cycle type, program counter and address register hold.
- R9: An E cycle reads at the address register and loads the word into the storage register. An L cycle makes no storage request and lasts one clock.
- R10: `eop_o` is high in the first clock of the I cycle that follows the last cycle of an instruction. Whenever `eop_o` is high, `cyc_o` is I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req_o | output | 1 | Storage read request |
| mem_addr_o | output | 15 | Storage read address |
| mem_valid_i | input | 1 | Read data valid; completes the current cycle |
| mem_rdata_i | input | 36 | Read data word |
| cyc_o | output | 2 | Current cycle type |
| eop_o | output | 1 | End-of-operation flag (first clock of next I) |
| pc_o | output | 15 | Program counter |
| sr_o | output | 36 | Storage register |
| pr_o | output | 12 | Program register (opcode field) |
| ar_o | output | 15 | Address register |
| sc_o | output | 8 | Shift counter |

## Verification
The bench targets the range edges at octal 177/200 and 677/700. A wrong comparison there would send a code into the wrong E or L cycle. It also covers a non-indexable code with the flags set, and a single flag bit alone. Either case would wrongly gain an IND cycle if indexability or the two-bit test were mishandled.

An indirect word carrying its own flag bits would cause a second IND cycle in a design that re-applied indirection. A single-cycle code with flags set, and a shift-group code, check that the address register is left alone and that no extra cycle appears. Every case runs under three memory latencies, so a design that moved on before valid data would show a corrupted trace or register value.

// File: rtl/icseq_pkg.sv
// Shared types of the instruction cycle sequencer.
// Assumes a 2-bit cycle code visible to the datapath.
package icseq_pkg;

    typedef enum logic [1:0] {
        CY_I   = 2'd0,
        CY_IND = 2'd1,
        CY_E   = 2'd2,
        CY_L   = 2'd3
    } cyc_t;

    typedef struct packed {
        logic single;
        logic ind_req;
        logic long_cyc;
        logic shift_grp;
    } dec_t;

endpackage

// File: rtl/icseq_decode.sv
// Opcode classifier: turns the primary code and the two indirect
// flag bits of a fetched word into the sequencing attributes.
// Assumes the primary code is the top CLS_W bits of the word and the
// shift group is the top GRP_W bits of that code.
module icseq_decode
    import icseq_pkg::*;
#(
    parameter int                       CLS_W       = 9,
    parameter int                       GRP_W       = 6,
    parameter logic [GRP_W-1:0]         SHIFT_GRP   = 6'o76,
    parameter int unsigned              LONG_LO_MAX = 'o177,
    parameter int unsigned              LONG_HI_MIN = 'o700,
    parameter logic [(1<<CLS_W)-1:0]    SINGLE_MAP  = '0,
    parameter logic [(1<<CLS_W)-1:0]    INDEX_MAP   = '0
) (
    input  logic [CLS_W-1:0] cls_i,
    input  logic [1:0]       ind_bits_i,
    output dec_t             dec_o
);

    localparam int unsigned CLS_MAX = (1 << CLS_W) - 1;

    logic in_low, in_high;

    // Range tests; a limit outside the code space disables that side.
    generate
        if (LONG_HI_MIN > CLS_MAX) begin : g_no_high
            assign in_high = 1'b0;
        end else begin : g_high
            assign in_high = (32'(cls_i) >= LONG_HI_MIN);
        end
    endgenerate
    assign in_low = (32'(cls_i) <= LONG_LO_MAX);

    // Attribute lookup for the fetched code.
    always_comb begin
        dec_o.single    = SINGLE_MAP[cls_i];
        dec_o.long_cyc  = in_low || in_high;
        dec_o.shift_grp = (cls_i[CLS_W-1 -: GRP_W] == SHIFT_GRP);
        dec_o.ind_req   = INDEX_MAP[cls_i] && !SINGLE_MAP[cls_i] && (&ind_bits_i);
    end

endmodule

// File: rtl/icseq_fsm.sv
// Cycle sequencer: steps I -> (IND) -> E/L -> I, holds on pending
// storage reads and raises a registered end-of-operation flag.
// Assumes decode inputs are valid in the clock the I read completes.
module icseq_fsm
    import icseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_valid_i,
    input  logic single_i,
    input  logic ind_req_i,
    input  logic long_i,
    output cyc_t cyc_o,
    output logic eop_o,
    output logic mem_req_o,
    output logic ld_fetch_o,
    output logic ld_ind_o,
    output logic ld_oper_o
);

    cyc_t cyc_q, cyc_d;
    logic eop_d;
    logic long_q, long_d;
    logic done;

    assign cyc_o     = cyc_q;
    assign mem_req_o = (cyc_q != CY_L);
    assign done      = mem_req_o ? mem_valid_i : 1'b1;

    // Next cycle choice and register load strobes.
    always_comb begin
        cyc_d      = cyc_q;
        eop_d      = 1'b0;
        long_d     = long_q;
        ld_fetch_o = 1'b0;
        ld_ind_o   = 1'b0;
        ld_oper_o  = 1'b0;
        if (done) begin
            unique case (cyc_q)
                CY_I: begin
                    ld_fetch_o = 1'b1;
                    long_d     = long_i;
                    if (single_i) begin
                        cyc_d = CY_I;
                        eop_d = 1'b1;
                    end else if (ind_req_i) begin
                        cyc_d = CY_IND;
                    end else begin
                        cyc_d = long_i ? CY_L : CY_E;
                    end
                end
                CY_IND: begin
                    ld_ind_o = 1'b1;
                    cyc_d    = long_q ? CY_L : CY_E;
                end
                CY_E: begin
                    ld_oper_o = 1'b1;
                    cyc_d     = CY_I;
                    eop_d     = 1'b1;
                end
                CY_L: begin
                    cyc_d = CY_I;
                    eop_d = 1'b1;
                end
                default: cyc_d = CY_I;
            endcase
        end
    end

    // State register; reset acts as an end of operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= CY_I;
            eop_o  <= 1'b1;
            long_q <= 1'b0;
        end else begin
            cyc_q  <= cyc_d;
            eop_o  <= eop_d;
            long_q <= long_d;
        end
    end

    // R10: the end flag only ever coincides with an I cycle.
    p_eop_in_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> (cyc_q == CY_I));

    // R8: a pending read keeps the cycle type.
    p_hold_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_valid_i) |=> $stable(cyc_q));

    // R6: after the indirect cycle comes E or L, never another IND.
    p_ind_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_IND && mem_valid_i) |=> (cyc_q == CY_E || cyc_q == CY_L));

    // R9: an L cycle lasts one clock and ends the operation.
    p_l_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CY_L) |=> (cyc_q == CY_I && eop_o));

endmodule

// File: rtl/icseq_regs.sv
// Sequencer register set: program counter, storage register, program
// register, address register and shift counter, plus the read address.
// Assumes at most one load strobe is active per clock.
module icseq_regs
    import icseq_pkg::*;
#(
    parameter int            WORD_W   = 36,
    parameter int            ADDR_W   = 15,
    parameter int            OPC_W    = 12,
    parameter int            SC_W     = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_t              cyc_i,
    input  logic              ld_fetch_i,
    input  logic              ld_ind_i,
    input  logic              ld_oper_i,
    input  logic              shift_grp_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] sr_o,
    output logic [OPC_W-1:0]  pr_o,
    output logic [ADDR_W-1:0] ar_o,
    output logic [SC_W-1:0]   sc_o
);

    logic [ADDR_W-1:0] pc_q, ar_q;
    logic [WORD_W-1:0] sr_q;
    logic [OPC_W-1:0]  pr_q;
    logic [SC_W-1:0]   sc_q;

    assign pc_o       = pc_q;
    assign sr_o       = sr_q;
    assign pr_o       = pr_q;
    assign ar_o       = ar_q;
    assign sc_o       = sc_q;
    assign mem_addr_o = (cyc_i == CY_I) ? pc_q : ar_q;

    // Program counter: steps once per completed fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= RESET_PC;
        else if (ld_fetch_i) pc_q <= pc_q + ADDR_W'(1);
    end

    // Storage register: instruction on fetch, operand on execute.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sr_q <= '0;
        else if (ld_fetch_i || ld_oper_i) sr_q <= rdata_i;
    end

    // Program register: opcode field of the fetched instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)          pr_q <= '0;
        else if (ld_fetch_i) pr_q <= rdata_i[WORD_W-1 -: OPC_W];
    end

    // Address register: fetched or indirect address field.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ar_q <= '0;
        else if (ld_fetch_i && !shift_grp_i) ar_q <= rdata_i[ADDR_W-1:0];
        else if (ld_ind_i)                   ar_q <= rdata_i[ADDR_W-1:0];
    end

    // Shift counter: low address bits of a shift-group instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)                         sc_q <= '0;
        else if (ld_fetch_i && shift_grp_i) sc_q <= rdata_i[SC_W-1:0];
    end

    // R2: each completed fetch advances the program counter by one.
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fetch_i |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

    // R8: without a completed fetch the program counter holds.
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_fetch_i |=> $stable(pc_q));

    // R6: the indirect read leaves instruction registers untouched.
    p_ind_keeps_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ind_i |=> ($stable(sr_q) && $stable(pr_q)));

    // R3: a shift-group fetch keeps the address register.
    p_shift_keeps_ar_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fetch_i && shift_grp_i) |=> $stable(ar_q));

endmodule

// File: rtl/icseq_top.sv
// Instruction cycle sequencer top: joins the opcode classifier, the
// cycle state machine and the register set around one read port.
// Assumes storage returns the word addressed while mem_req_o is high.
module icseq_top
    import icseq_pkg::*;
#(
    parameter int                WORD_W   = 36,
    parameter int                ADDR_W   = 15,
    parameter int                OPC_W    = 12,
    parameter int                CLS_W    = 9,
    parameter int                SC_W     = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter logic [(1<<CLS_W)-1:0] SINGLE_MAP =
        {{((1<<CLS_W)-1){1'b0}}, 1'b1} << 'o761,
    parameter logic [(1<<CLS_W)-1:0] INDEX_MAP =
        (({(1<<CLS_W){1'b1}} << 'o200) & ~({(1<<CLS_W){1'b1}} << 'o700))
        | ({{((1<<CLS_W)-1){1'b0}}, 1'b1} << 'o100)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_valid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic [1:0]        cyc_o,
    output logic              eop_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] sr_o,
    output logic [OPC_W-1:0]  pr_o,
    output logic [ADDR_W-1:0] ar_o,
    output logic [SC_W-1:0]   sc_o
);

    // Flag bits 12 and 13, counted from the sign bit.
    localparam int IND_HI = WORD_W - 1 - 12;

    dec_t dec;
    cyc_t cyc;
    logic ld_fetch, ld_ind, ld_oper;

    assign cyc_o = cyc;

    icseq_decode #(
        .CLS_W      (CLS_W),
        .SINGLE_MAP (SINGLE_MAP),
        .INDEX_MAP  (INDEX_MAP)
    ) u_decode (
        .cls_i      (mem_rdata_i[WORD_W-1 -: CLS_W]),
        .ind_bits_i (mem_rdata_i[IND_HI -: 2]),
        .dec_o      (dec)
    );

    icseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_valid_i (mem_valid_i),
        .single_i    (dec.single),
        .ind_req_i   (dec.ind_req),
        .long_i      (dec.long_cyc),
        .cyc_o       (cyc),
        .eop_o       (eop_o),
        .mem_req_o   (mem_req_o),
        .ld_fetch_o  (ld_fetch),
        .ld_ind_o    (ld_ind),
        .ld_oper_o   (ld_oper)
    );

    icseq_regs #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .OPC_W    (OPC_W),
        .SC_W     (SC_W),
        .RESET_PC (RESET_PC)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_i       (cyc),
        .ld_fetch_i  (ld_fetch),
        .ld_ind_i    (ld_ind),
        .ld_oper_i   (ld_oper),
        .shift_grp_i (dec.shift_grp),
        .rdata_i     (mem_rdata_i),
        .mem_addr_o  (mem_addr_o),
        .pc_o        (pc_o),
        .sr_o        (sr_o),
        .pr_o        (pr_o),
        .ar_o        (ar_o),
        .sc_o        (sc_o)
    );

endmodule

// File: tb/icseq_top_bench.sv
// Bench: a program of vectors runs under three read latencies; each
// instruction's cycle trace and registers are checked at end-of-op.
module icseq_top_bench;

    function automatic logic [35:0] mk(input logic [8:0] cls, input logic [1:0] ib,
                                       input logic [14:0] a);
        return {cls, 3'b000, ib, 7'b0, a};
    endfunction

    localparam int NV = 12;
    // Trace digits: I=1, IND=2, E=3, L=4 (cycle code + 1), oldest first.
    localparam logic [35:0] PROG [NV] = '{
        mk(9'o500, 2'b00, 15'o41),   // E plain
        mk(9'o500, 2'b11, 15'o42),   // E via indirect
        mk(9'o100, 2'b11, 15'o44),   // L via indirect (indexable)
        mk(9'o040, 2'b11, 15'o46),   // L, not indexable: flags ignored
        mk(9'o761, 2'b11, 15'o312),  // single-cycle, shift group
        mk(9'o763, 2'b00, 15'o155),  // shift group L
        mk(9'o177, 2'b00, 15'o47),   // upper edge of low L range
        mk(9'o200, 2'b00, 15'o50),   // lower edge of E range
        mk(9'o677, 2'b10, 15'o51),   // upper edge of E range, one flag only
        mk(9'o700, 2'b00, 15'o52),   // lower edge of high L range
        mk(9'o777, 2'b01, 15'o53),   // top code, one flag only
        mk(9'o300, 2'b11, 15'o54)    // indirect word carries flags too
    };
    localparam logic [11:0] EXP_TR [NV] = '{
        12'o13, 12'o123, 12'o124, 12'o14, 12'o1, 12'o14,
        12'o14, 12'o13, 12'o13, 12'o14, 12'o14, 12'o123
    };
    localparam logic [14:0] EXP_AR [NV] = '{
        15'o41, 15'o43, 15'o45, 15'o46, 15'o46, 15'o46,
        15'o47, 15'o50, 15'o51, 15'o52, 15'o53, 15'o55
    };
    localparam logic [7:0] EXP_SC [NV] = '{
        8'o0, 8'o0, 8'o0, 8'o0, 8'o312, 8'o155,
        8'o155, 8'o155, 8'o155, 8'o155, 8'o155, 8'o155
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_valid = 1'b0, eop;
    logic [14:0] mem_addr, pc, ar;
    logic [35:0] mem_rdata = '0, sr;
    logic [11:0] pr;
    logic [7:0]  sc;
    logic [1:0]  cyc;

    logic [35:0] mem [64];
    int          lat = 0, cnt = 0, n_cmp = 0, n_bad = 0, l_reads = 0, cycles = 0;
    logic [11:0] trace = '0;

    icseq_top u_icseq_top (
        .clk (clk), .rst_n (rst_n),
        .mem_req_o (mem_req), .mem_addr_o (mem_addr),
        .mem_valid_i (mem_valid), .mem_rdata_i (mem_rdata),
        .cyc_o (cyc), .eop_o (eop), .pc_o (pc), .sr_o (sr),
        .pr_o (pr), .ar_o (ar), .sc_o (sc)
    );

    always #5 clk = ~clk;

    // Storage model: valid after lat idle negedges, dropped after use.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_valid = 1'b0; cnt = 0;
        end else if (mem_valid) begin
            mem_valid = 1'b0; cnt = 0;
        end else if (mem_req) begin
            if (cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = mem[mem_addr[5:0]];
            end else cnt++;
        end else cnt = 0;
    end

    // Trace monitor: logs each completed cycle (R9: no read in L).
    always @(posedge clk) begin
        if (rst_n) begin
            if (cyc == 2'd3 || (mem_req && mem_valid))
                trace = {trace[8:0], 3'(cyc) + 3'd1};
            if (cyc == 2'd3 && mem_req) l_reads++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", cycles, 20000);
            summary();
        end
    end

    // R1: reset state, checked while reset is held.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(cyc == 2'd0, "R1 cyc", 36'(cyc), 36'd0);
        chk(eop == 1'b1, "R1 eop", 36'(eop), 36'd1);
        chk(pc == 15'd0 && ar == 15'd0, "R1 pc/ar", 36'({pc, ar}), 36'd0);
        chk(sc == 8'd0 && sr == 36'd0 && pr == 12'd0, "R1 sc/sr/pr",
            36'(sc) | sr, 36'd0);
        chk(mem_req && mem_addr == 15'd0, "R1 fetch at pc", 36'(mem_addr), 36'd0);
        rst_n = 1'b1;
        trace = '0;
    endtask

    // Vector walk: wait for each end-of-op, then compare (R2..R7, R9, R10).
    task automatic run_vectors();
        for (int k = 0; k < NV; k++) begin
            logic [35:0] exp_sr;
            do @(negedge clk); while (!eop);
            chk(cyc == 2'd0, "R10 eop in I", 36'(cyc), 36'd0);
            chk(trace == EXP_TR[k], "R4/R5/R6/R7 cycle trace", 36'(trace), 36'(EXP_TR[k]));
            chk(ar == EXP_AR[k], "R3/R6 address reg", 36'(ar), 36'(EXP_AR[k]));
            chk(sc == EXP_SC[k], "R3 shift counter", 36'(sc), 36'(EXP_SC[k]));
            chk(pc == 15'(k + 1), "R2 program counter", 36'(pc), 36'(k + 1));
            chk(pr == PROG[k][35:24], "R2 program reg", 36'(pr), 36'(PROG[k][35:24]));
            exp_sr = (EXP_TR[k][2:0] == 3'd3) ? mem[EXP_AR[k][5:0]] : PROG[k];
            chk(sr == exp_sr, "R9/R6 storage reg", sr, exp_sr);
            trace = '0;
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 36'(i) * 36'd1234567 + 36'd99;
        for (int k = 0; k < NV; k++) mem[k] = PROG[k];
        mem[6'o42] = mk(9'o777, 2'b11, 15'o43);
        mem[6'o44] = mk(9'o500, 2'b00, 15'o45);
        mem[6'o54] = mk(9'o000, 2'b11, 15'o55);

        for (int pass = 0; pass < 3; pass++) begin
            lat = (pass == 0) ? 0 : (pass == 1) ? 3 : 5;
            do_reset();
            if (pass == 2) begin
                // R8: slow storage, the first fetch must wait.
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    chk(cyc == 2'd0 && pc == 15'd0 && mem_req, "R8 hold in I",
                        36'({cyc, pc}), 36'd0);
                end
            end
            run_vectors();
        end
        chk(l_reads == 0, "R9 no request in L", 36'(l_reads), 36'd0);
        summary();
    end

endmodule